// File: doc/BRIEF.md
# Dual-rail low-voltage reset controller

This block is the digital side of a supply monitor. It watches two rails, the main supply and an internal regulator output. For each rail an external comparator gives a one-bit "rail is low" indication, and that comparator already supplies the hysteresis. Both indications are asynchronous. Each one passes through a two-flop synchronizer. It is then qualified by configuration: a per-rail off bit, and a stop-mode rule that treats both detectors as powered down while a stop is in effect unless stop monitoring is enabled. The qualified indications are ORed into a pollable status flag.

When the flag rises and reset generation is not blocked, the controller enters a reset hold. It keeps its reset request asserted, and drives the active-low external reset pin low, for as long as any enabled rail still reads low. Once all enabled rails read good, it waits a programmable stretch time before releasing reset. A new low reading during the stretch sends it back to the hold. A sticky source bit records that the last reset came from low voltage, and a write-one-to-clear pulse clears it.

The states are RUN (reset released), TRIP (reset held while a rail is low) and STRETCH (reset held while the release counter runs). The transitions are:
- RUN to TRIP when the flag is set and resets are not blocked.
- TRIP to STRETCH when the flag is clear.
- STRETCH to TRIP when the flag is set.
- STRETCH to RUN when the counter reaches its last count.

Power-on reset puts the controller in TRIP.

Top module: `lvi_reset_ctrl`

## Requirements
- R1: Each rail indication goes through two synchronizing flops. A change applied between clock edges shows on `low_flag` after the second rising edge and not after the first.
- R2: `low_flag` is the OR of the synchronized indications of the rails that are enabled and not powered down. It is 1 when any such rail reads 1 (low) and 0 otherwise.
- R3: With `cfg_main_off`=1 the main-rail input has no effect on `low_flag` or on reset. With `cfg_reg_off`=1 the regulator input has no effect on either.
- R4: With `stop_active`=1 and `cfg_stop_keep`=0 both rail inputs are ignored. With `cfg_stop_keep`=1 monitoring continues during stop.
- R5: With `cfg_rst_block`=0, an enabled rail going low raises `rst_req` on the third rising edge after the input change.
- R6: With `cfg_rst_block`=1 no new low-voltage reset starts, while `low_flag` still tracks the rails.
- R7: Once a reset has started, `rst_req` stays 1 while any enabled rail still reads low, so release waits for both rails to recover.
- R8: After both rails read good, `rst_req` falls STRETCH_CYC edges after the FSM leaves TRIP. With the default of 16 this is the 19th edge after the input change. A low reading during the stretch restarts the hold.
- R9: During power-on reset (`rst_n`=0) `rst_req`=1, `low_flag`=0 and `src_lvi`=0. After release, with the rails good, `rst_req` falls on edge STRETCH_CYC+1 (17 by default).
- R10: `src_lvi` goes to 1 in the cycle a low-voltage reset starts. A one-cycle `clr_src` pulse clears it at the next edge, unless a new reset starts in that same edge.
- R11: `rst_pin_n` is always the inverse of `rst_req`, so a low-voltage reset drives the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| main_low_in | input | 1 | Main-rail comparator, 1 = low (async) |
| reg_low_in | input | 1 | Regulator-rail comparator, 1 = low (async) |
| cfg_main_off | input | 1 | 1 = main-rail monitoring off |
| cfg_reg_off | input | 1 | 1 = regulator-rail monitoring off |
| cfg_rst_block | input | 1 | 1 = low-voltage resets blocked, flag still live |
| cfg_stop_keep | input | 1 | 1 = keep monitoring during stop |
| stop_active | input | 1 | 1 = a stop is in effect |
| clr_src | input | 1 | Write-one-to-clear pulse for `src_lvi` |
| low_flag | output | 1 | Status flag |
| rst_req | output | 1 | Internal reset request, active high |
| rst_pin_n | output | 1 | External reset pin drive, active low |
| src_lvi | output | 1 | Sticky: last reset was low voltage |

## Verification
The flag is tried with each rail low on its own, both rails low, and each off bit set against a low input. This separates the OR from either single rail and shows that masking applies per rail. The stop cases cross stop with the keep bit, which tells power-down apart from continued monitoring. Rows that differ only in the block bit confirm that blocking suppresses the reset but not the flag. Directed sequences release one rail while the other stays low, and re-trip a rail in mid-stretch. These separate "any rail recovered" from "all rails recovered" and a restarting stretch counter from a free-running one.

// File: rtl/lvi_pkg.sv
package lvi_pkg;
    localparam int RAILS = 2;
    localparam int RAIL_MAIN = 0;
    localparam int RAIL_REG = 1;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_TRIP    = 2'd1,
        ST_STRETCH = 2'd2
    } lvi_state_e;
endpackage

// File: rtl/lvi_sync.sv
module lvi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lvi_qual.sv
module lvi_qual
    import lvi_pkg::*;
(
    input  logic [RAILS-1:0] low_sync,
    input  logic [RAILS-1:0] rail_off,
    input  logic             stop_active,
    input  logic             stop_keep,
    output logic             low_any
);
    logic             pwr_down;
    logic [RAILS-1:0] rail_live;

    assign pwr_down = stop_active & ~stop_keep;

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        assign rail_live[r] = low_sync[r] & ~rail_off[r] & ~pwr_down;
    end

    assign low_any = |rail_live;
endmodule

// File: rtl/lvi_seq.sv
module lvi_seq
    import lvi_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_any,
    input  logic rst_block,
    input  logic clr_src,
    output logic rst_req,
    output logic rst_pin_n,
    output logic src_lvi
);
    localparam int CW = (STRETCH_CYC < 2) ? 1 : $clog2(STRETCH_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(STRETCH_CYC - 1);

    lvi_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic trip_start;

    assign trip_start = (state_q == ST_RUN) && low_any && !rst_block;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRIP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (trip_start) state_d = ST_TRIP;
            ST_TRIP:    if (!low_any) state_d = ST_STRETCH;
            ST_STRETCH: begin
                if (low_any)                state_d = ST_TRIP;
                else if (cnt_q == CNT_LAST) state_d = ST_RUN;
            end
            default:    state_d = ST_TRIP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (state_q == ST_STRETCH) cnt_q <= cnt_q + 1'b1;
        else                            cnt_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          src_lvi <= 1'b0;
        else if (trip_start) src_lvi <= 1'b1;
        else if (clr_src)    src_lvi <= 1'b0;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  begin rst_req = 1'b0; rst_pin_n = 1'b1; end
            default: begin rst_req = 1'b1; rst_pin_n = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lvi_reset_ctrl.sv
module lvi_reset_ctrl
    import lvi_pkg::*;
#(
    parameter int STRETCH_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_low_in,
    input  logic reg_low_in,
    input  logic cfg_main_off,
    input  logic cfg_reg_off,
    input  logic cfg_rst_block,
    input  logic cfg_stop_keep,
    input  logic stop_active,
    input  logic clr_src,
    output logic low_flag,
    output logic rst_req,
    output logic rst_pin_n,
    output logic src_lvi
);
    logic [RAILS-1:0] low_raw, low_sync, rail_off;

    assign low_raw[RAIL_MAIN]  = main_low_in;
    assign low_raw[RAIL_REG]   = reg_low_in;
    assign rail_off[RAIL_MAIN] = cfg_main_off;
    assign rail_off[RAIL_REG]  = cfg_reg_off;

    lvi_sync #(.WIDTH(RAILS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (low_raw),
        .q_sync  (low_sync)
    );

    lvi_qual u_qual (
        .low_sync    (low_sync),
        .rail_off    (rail_off),
        .stop_active (stop_active),
        .stop_keep   (cfg_stop_keep),
        .low_any     (low_flag)
    );

    lvi_seq #(.STRETCH_CYC(STRETCH_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_any   (low_flag),
        .rst_block (cfg_rst_block),
        .clr_src   (clr_src),
        .rst_req   (rst_req),
        .rst_pin_n (rst_pin_n),
        .src_lvi   (src_lvi)
    );
endmodule

// File: rtl/lvi_reset_ctrl_chk.sv
module lvi_reset_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_rst_block,
    input logic clr_src,
    input logic low_flag,
    input logic rst_req,
    input logic rst_pin_n,
    input logic src_lvi
);
    assert_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_flag && !cfg_rst_block && !rst_req) |=> rst_req);

    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && cfg_rst_block) |=> !rst_req);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && low_flag) |=> rst_req);

    assert_src_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_lvi) |-> rst_req);

    assert_src_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_src && !(low_flag && !cfg_rst_block && !rst_req)) |=> !src_lvi);

    assert_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_n != rst_req);
endmodule

bind lvi_reset_ctrl lvi_reset_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rst_block (cfg_rst_block),
    .clr_src       (clr_src),
    .low_flag      (low_flag),
    .rst_req       (rst_req),
    .rst_pin_n     (rst_pin_n),
    .src_lvi       (src_lvi)
);

// File: tb/lvi_reset_ctrl_tb.sv
`timescale 1ns/1ps
module lvi_reset_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_low_in = 0, reg_low_in = 0;
    logic cfg_main_off = 0, cfg_reg_off = 0, cfg_rst_block = 0;
    logic cfg_stop_keep = 0, stop_active = 0, clr_src = 0;
    logic low_flag, rst_req, rst_pin_n, src_lvi;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    lvi_reset_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .main_low_in(main_low_in), .reg_low_in(reg_low_in),
        .cfg_main_off(cfg_main_off), .cfg_reg_off(cfg_reg_off),
        .cfg_rst_block(cfg_rst_block), .cfg_stop_keep(cfg_stop_keep),
        .stop_active(stop_active), .clr_src(clr_src),
        .low_flag(low_flag), .rst_req(rst_req),
        .rst_pin_n(rst_pin_n), .src_lvi(src_lvi)
    );

    // bits: main reg moff roff blk stop keep | exp_flag exp_rst
    localparam logic [8:0] VEC [13] = '{
        9'b1_0_0_0_1_0_0_1_0,  // R2 main only, blocked (R6)
        9'b0_1_0_0_1_0_0_1_0,  // R2 reg only
        9'b1_0_1_0_1_0_0_0_0,  // R3 main off
        9'b0_1_0_1_1_0_0_0_0,  // R3 reg off
        9'b1_1_1_1_0_0_0_0_0,  // R3 both off, no reset
        9'b1_0_0_0_1_1_0_0_0,  // R4 stop powers down
        9'b1_0_0_0_1_1_1_1_0,  // R4 stop keep main
        9'b0_1_0_0_1_1_1_1_0,  // R4 stop keep reg
        9'b1_1_1_0_1_0_0_1_0,  // R2 reg still enabled
        9'b1_0_0_0_0_0_0_1_1,  // R5 main trips reset
        9'b0_1_0_0_0_0_0_1_1,  // R5 reg trips reset
        9'b1_0_0_0_0_1_0_0_0,  // R4 stop, no reset
        9'b1_0_1_0_0_0_0_0_0   // R3 off, no reset
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic settle_clear();
        main_low_in = 0; reg_low_in = 0;
        repeat (25) @(negedge clk);
        cfg_main_off = 0; cfg_reg_off = 0; cfg_rst_block = 0;
        cfg_stop_keep = 0; stop_active = 0;
        clr_src = 1;
        @(negedge clk);
        clr_src = 0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 rst_req in reset", rst_req, 1'b1);
        chk("R9 flag in reset", low_flag, 1'b0);
        chk("R9 src in reset", src_lvi, 1'b0);
        chk("R11 pin in reset", rst_pin_n, 1'b0);
        rst_n = 1;
        repeat (16) @(negedge clk);
        chk("R9 held edge 16", rst_req, 1'b1);
        @(negedge clk);
        chk("R9 released edge 17", rst_req, 1'b0);
        chk("R9 src after power-on", src_lvi, 1'b0);

        // vector table
        foreach (VEC[i]) begin
            {main_low_in, reg_low_in, cfg_main_off, cfg_reg_off,
             cfg_rst_block, stop_active, cfg_stop_keep} = VEC[i][8:2];
            repeat (4) @(negedge clk);
            chk("R2/R3/R4 flag row", low_flag, VEC[i][1]);
            chk("R5/R6 reset row", rst_req, VEC[i][0]);
            chk("R11 pin row", rst_pin_n, ~VEC[i][0]);
            settle_clear();
        end

        // R1 and R5 edge timing
        main_low_in = 1;
        @(negedge clk);
        chk("R1 flag after 1 edge", low_flag, 1'b0);
        @(negedge clk);
        chk("R1 flag after 2 edges", low_flag, 1'b1);
        chk("R5 no reset after 2 edges", rst_req, 1'b0);
        @(negedge clk);
        chk("R5 reset after 3 edges", rst_req, 1'b1);
        chk("R11 pin low", rst_pin_n, 1'b0);
        chk("R10 src set", src_lvi, 1'b1);
        main_low_in = 0;
        repeat (25) @(negedge clk);
        chk("R10 src held", src_lvi, 1'b1);
        clr_src = 1;
        @(negedge clk);
        clr_src = 0;
        chk("R10 src cleared", src_lvi, 1'b0);

        // R7 hold until both recover, R8 stretch
        main_low_in = 1; reg_low_in = 1;
        repeat (4) @(negedge clk);
        chk("R7 reset on both low", rst_req, 1'b1);
        main_low_in = 0;
        repeat (25) @(negedge clk);
        chk("R7 held while reg low", rst_req, 1'b1);
        reg_low_in = 0;
        repeat (18) @(negedge clk);
        chk("R8 held edge 18", rst_req, 1'b1);
        @(negedge clk);
        chk("R8 released edge 19", rst_req, 1'b0);
        settle_clear();

        // R8 restart during stretch
        main_low_in = 1;
        repeat (4) @(negedge clk);
        main_low_in = 0;
        repeat (10) @(negedge clk);
        main_low_in = 1;
        repeat (12) @(negedge clk);
        chk("R8 stretch restarted", rst_req, 1'b1);
        main_low_in = 0;
        repeat (18) @(negedge clk);
        chk("R8 restart held edge 18", rst_req, 1'b1);
        @(negedge clk);
        chk("R8 restart released edge 19", rst_req, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule